// File: doc/BRIEF.md
# Current-Sense Amplifier Offset Calibration Sequencer

This controller sequences DC offset calibration for a set of low-side current-sense amplifier channels, three by default. For each channel it drives two analog controls: one shorts the amplifier inputs together and one disconnects the shunt resistor. It also drives a gain override, a direction override, a busy flag and a trim-valid flag. The user's gain and direction settings pass through unchanged when no calibration is active.

A calibration request comes either from a shared pin, which acts on all channels at once, or from a per-channel register bit. A mode bit decides what a request does. With the mode bit at 0 the request starts a manual calibration: the inputs stay shorted for as long as the request is held, and the channel reports busy for a fixed settling window. With the mode bit at 1 the request starts a timed automatic routine, but only when the run-time enable is set. The automatic routine also runs once by itself, on the first rise of the reference-valid flag after reset.

During an automatic run the channel is forced to bidirectional operation at maximum gain. When the run ends, a trim-valid flag is latched and the user's configuration returns. The analog trim search is modelled only as this timed window. The window length is derived from a clock-frequency parameter and a duration parameter of 50 µs. A hardware-only variant ignores the register bits and always treats the pin as a manual request.

Top module: `csa_cal_seq`

## Requirements
- R1: A channel that is calibrating, in either manual or automatic mode, has both `short_o` and `shunt_off_o` high. An idle channel has both low.
- R2: A high `cal_pin_i` acts on every channel. Bit c of `cal_reg_i` acts only on channel c.
- R3: With `auto_mode_i` = 0 a request gives manual calibration. With `auto_mode_i` = 1 the rising edge of a request gives automatic calibration, in which busy is high and the gain and direction overrides apply.
- R4: When `HW_ONLY` = 1, `cal_reg_i` has no effect and the pin always gives manual calibration, whatever the value of `auto_mode_i`.
- R5: The first cycle after reset in which `vref_ok_i` is high starts automatic calibration on all channels. Later rises of `vref_ok_i` start nothing. An automatic run keeps busy high for WIN cycles and then sets `trim_valid_o`, which stays set until the next automatic run starts or the block is reset.
- R6: During an automatic run `uni_o` of the channel is 0, which means bidirectional. Outside a run, `uni_o` equals `uni_cfg_i`.
- R7: During an automatic run the gain slice of the channel in `gain_o` is all ones. Outside a run it equals the slice in `gain_cfg_i`.
- R8: In manual calibration busy is high for exactly WIN cycles after entry. After that the shorts stay on, with busy low, for as long as the request is held.
- R9: A run-time automatic request is ignored when `auto_en_i` = 0: no override and no busy.
- R10: A new rising request that qualifies for automatic calibration during an automatic run reloads the window, so busy lasts WIN cycles from the new request.
- R11: When a manual request drops, the channel returns to normal on the next clock.
- R12: After asynchronous reset all channels are idle, all overrides are inactive and `trim_valid_o` is 0.

WIN = CLK_FREQ_HZ/1000 × CAL_TIME_US/1000 cycles, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cal_pin_i | input | 1 | Shared calibration request for all channels |
| cal_reg_i | input | NUM_CH | Per-channel calibration request bits |
| auto_mode_i | input | 1 | 0 = manual, 1 = automatic |
| auto_en_i | input | 1 | Enables run-time automatic calibration |
| vref_ok_i | input | 1 | Reference voltage valid |
| gain_cfg_i | input | NUM_CH*GAIN_W | Configured gain, channel c at [c*GAIN_W +: GAIN_W] |
| uni_cfg_i | input | NUM_CH | Configured direction, 1 = unidirectional |
| short_o | output | NUM_CH | Short amplifier inputs |
| shunt_off_o | output | NUM_CH | Disconnect shunt resistor |
| gain_o | output | NUM_CH*GAIN_W | Effective gain |
| uni_o | output | NUM_CH | Effective direction |
| busy_o | output | NUM_CH | Calibration window running |
| trim_valid_o | output | NUM_CH | Trim stored by an automatic run |

## Verification
The embedded assertions check these rules on every cycle:
- the window counter stays in range;
- a dropped manual request leads to idle on the next cycle;
- `trim_valid_o` rises only out of an automatic run;
- an automatic run always shows maximum gain and bidirectional mode at the ports;
- in the hardware-only variant the request follows the pin alone.

Some behaviour only the bench scenarios can show: that power-up calibration happens exactly once, that the window is reloaded on a retrigger, that a disabled run-time request is ignored, and that the per-channel bits are isolated from each other. A behavioural model tracks both the default variant and the hardware-only variant, and their outputs are compared on every clock.

// File: rtl/csa_cal_pkg.sv
`timescale 1ns/1ps
package csa_cal_pkg;

  typedef enum logic [1:0] {
    CS_IDLE     = 2'd0,
    CS_MAN_WAIT = 2'd1,
    CS_MAN_HOLD = 2'd2,
    CS_AUTO     = 2'd3
  } cal_st_e;

  // settle window in clock cycles, at least one
  function automatic int cal_cycles(input int clk_hz, input int dur_us);
    int c;
    c = ((clk_hz / 1000) * dur_us) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/csa_cal_req.sv
`timescale 1ns/1ps
module csa_cal_req #(
  parameter int NUM_CH  = 3,
  parameter bit HW_ONLY = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cal_pin_i,
  input  logic [NUM_CH-1:0] cal_reg_i,
  input  logic              auto_mode_i,
  input  logic              auto_en_i,
  input  logic              vref_ok_i,
  output logic [NUM_CH-1:0] req_o,
  output logic [NUM_CH-1:0] auto_start_o,
  output logic              manual_sel_o,
  output logic              pwr_start_o
);

  logic [NUM_CH-1:0] req_q;
  logic              pwr_done_q;
  logic              auto_sel;

  assign auto_sel     = auto_mode_i & ~HW_ONLY;
  assign manual_sel_o = ~auto_sel;
  assign pwr_start_o  = vref_ok_i & ~pwr_done_q;

  generate
    if (HW_ONLY) begin : g_hw
      assign req_o = {NUM_CH{cal_pin_i}};
    end else begin : g_sw
      assign req_o = {NUM_CH{cal_pin_i}} | cal_reg_i;
    end
  endgenerate

  assign auto_start_o = (req_o & ~req_q) & {NUM_CH{auto_sel & auto_en_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q      <= '0;
      pwr_done_q <= 1'b0;
    end else begin
      req_q <= req_o;
      if (vref_ok_i) pwr_done_q <= 1'b1;
    end
  end

  a_r5_pwr_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_start_o |=> !pwr_start_o);

  a_r9_no_auto_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_en_i || !auto_mode_i) |-> (auto_start_o == '0));

  generate
    if (HW_ONLY) begin : g_hw_chk
      a_r4_reg_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (auto_start_o == '0) && (req_o == {NUM_CH{cal_pin_i}}));
    end
  endgenerate

endmodule

// File: rtl/csa_cal_chan.sv
`timescale 1ns/1ps
module csa_cal_chan
  import csa_cal_pkg::*;
#(
  parameter int WIN_CYC = 5000
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    manual_sel_i,
  input  logic    auto_start_i,
  input  logic    pwr_start_i,
  output cal_st_e st_o,
  output logic    busy_o,
  output logic    trim_valid_o
);

  localparam int CNT_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_CYC - 1);

  cal_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             trim_q, trim_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    trim_d = trim_q;
    if (pwr_start_i || auto_start_i) begin
      st_d   = CS_AUTO;
      cnt_d  = CNT_LOAD;
      trim_d = 1'b0;
    end else begin
      unique case (st_q)
        CS_IDLE: begin
          if (req_i && manual_sel_i) begin
            st_d  = CS_MAN_WAIT;
            cnt_d = CNT_LOAD;
          end
        end
        CS_MAN_WAIT: begin
          if (!req_i) begin
            st_d  = CS_IDLE;
            cnt_d = '0;
          end else if (cnt_q == '0) begin
            st_d = CS_MAN_HOLD;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        CS_MAN_HOLD: begin
          if (!req_i) st_d = CS_IDLE;
        end
        CS_AUTO: begin
          if (cnt_q == '0) begin
            st_d   = CS_IDLE;
            trim_d = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: st_d = CS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CS_IDLE;
      cnt_q  <= '0;
      trim_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      trim_q <= trim_d;
    end
  end

  assign st_o         = st_q;
  assign busy_o       = (st_q == CS_MAN_WAIT) || (st_q == CS_AUTO);
  assign trim_valid_o = trim_q;

  a_r10_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LOAD);

  a_r11_drop_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == CS_MAN_WAIT || st_q == CS_MAN_HOLD) && !req_i && !pwr_start_i && !auto_start_i)
    |=> (st_q == CS_IDLE));

  a_r5_trim_from_auto: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trim_valid_o) |-> ($past(st_q) == CS_AUTO));

  a_r8_man_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CS_MAN_WAIT && cnt_q != '0 && req_i && !pwr_start_i && !auto_start_i) |=> busy_o);

endmodule

// File: rtl/csa_cal_ovr.sv
`timescale 1ns/1ps
module csa_cal_ovr
  import csa_cal_pkg::*;
#(
  parameter int GAIN_W = 2
) (
  input  cal_st_e           st_i,
  input  logic [GAIN_W-1:0] gain_cfg_i,
  input  logic              uni_cfg_i,
  output logic              short_o,
  output logic              shunt_off_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic              uni_o
);

  logic in_cal, in_auto;

  assign in_cal      = (st_i != CS_IDLE);
  assign in_auto     = (st_i == CS_AUTO);
  assign short_o     = in_cal;
  assign shunt_off_o = in_cal;
  assign gain_o      = in_auto ? {GAIN_W{1'b1}} : gain_cfg_i;
  assign uni_o       = in_auto ? 1'b0 : uni_cfg_i;

endmodule

// File: rtl/csa_cal_seq.sv
`timescale 1ns/1ps
module csa_cal_seq
  import csa_cal_pkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int GAIN_W      = 2,
  parameter int CLK_FREQ_HZ = 100_000_000,
  parameter int CAL_TIME_US = 50,
  parameter bit HW_ONLY     = 1'b0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cal_pin_i,
  input  logic [NUM_CH-1:0]        cal_reg_i,
  input  logic                     auto_mode_i,
  input  logic                     auto_en_i,
  input  logic                     vref_ok_i,
  input  logic [NUM_CH*GAIN_W-1:0] gain_cfg_i,
  input  logic [NUM_CH-1:0]        uni_cfg_i,
  output logic [NUM_CH-1:0]        short_o,
  output logic [NUM_CH-1:0]        shunt_off_o,
  output logic [NUM_CH*GAIN_W-1:0] gain_o,
  output logic [NUM_CH-1:0]        uni_o,
  output logic [NUM_CH-1:0]        busy_o,
  output logic [NUM_CH-1:0]        trim_valid_o
);

  localparam int WIN_CYC = cal_cycles(CLK_FREQ_HZ, CAL_TIME_US);

  logic [NUM_CH-1:0] req, auto_start;
  logic              manual_sel, pwr_start;
  cal_st_e           st [NUM_CH];

  csa_cal_req #(.NUM_CH(NUM_CH), .HW_ONLY(HW_ONLY)) u_req (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cal_pin_i    (cal_pin_i),
    .cal_reg_i    (cal_reg_i),
    .auto_mode_i  (auto_mode_i),
    .auto_en_i    (auto_en_i),
    .vref_ok_i    (vref_ok_i),
    .req_o        (req),
    .auto_start_o (auto_start),
    .manual_sel_o (manual_sel),
    .pwr_start_o  (pwr_start)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      csa_cal_chan #(.WIN_CYC(WIN_CYC)) u_chan (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .req_i        (req[c]),
        .manual_sel_i (manual_sel),
        .auto_start_i (auto_start[c]),
        .pwr_start_i  (pwr_start),
        .st_o         (st[c]),
        .busy_o       (busy_o[c]),
        .trim_valid_o (trim_valid_o[c])
      );

      csa_cal_ovr #(.GAIN_W(GAIN_W)) u_ovr (
        .st_i        (st[c]),
        .gain_cfg_i  (gain_cfg_i[c*GAIN_W +: GAIN_W]),
        .uni_cfg_i   (uni_cfg_i[c]),
        .short_o     (short_o[c]),
        .shunt_off_o (shunt_off_o[c]),
        .gain_o      (gain_o[c*GAIN_W +: GAIN_W]),
        .uni_o       (uni_o[c])
      );

      a_r6_r7_auto_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st[c] == CS_AUTO) |-> ((gain_o[c*GAIN_W +: GAIN_W] == {GAIN_W{1'b1}}) && !uni_o[c]
                                && busy_o[c]));

      a_r1_short_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o[c] |-> (short_o[c] && shunt_off_o[c]));
    end
  endgenerate

endmodule

// File: tb/csa_cal_seq_tb_top.sv
`timescale 1ns/1ps
module csa_cal_seq_tb_top;

  localparam int NCH = 3;
  localparam int GW  = 2;
  localparam int CLK_HZ = 200_000;  // scales the window to 10 cycles
  localparam int N   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_pin = 1'b0;
  logic [NCH-1:0] cal_reg = '0;
  logic auto_mode = 1'b0, auto_en = 1'b0, vref_ok = 1'b0;
  logic [NCH*GW-1:0] gain_cfg = 6'b00_10_01;
  logic [NCH-1:0] uni_cfg = 3'b101;

  logic [NCH-1:0]    sh [2], so [2], un [2], bz [2], tv [2];
  logic [NCH*GW-1:0] gn [2];

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  csa_cal_seq #(.NUM_CH(NCH), .GAIN_W(GW), .CLK_FREQ_HZ(CLK_HZ), .CAL_TIME_US(50),
                .HW_ONLY(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cal_pin_i(cal_pin), .cal_reg_i(cal_reg),
    .auto_mode_i(auto_mode), .auto_en_i(auto_en), .vref_ok_i(vref_ok),
    .gain_cfg_i(gain_cfg), .uni_cfg_i(uni_cfg), .short_o(sh[0]), .shunt_off_o(so[0]),
    .gain_o(gn[0]), .uni_o(un[0]), .busy_o(bz[0]), .trim_valid_o(tv[0]));

  csa_cal_seq #(.NUM_CH(NCH), .GAIN_W(GW), .CLK_FREQ_HZ(CLK_HZ), .CAL_TIME_US(50),
                .HW_ONLY(1'b1)) dut_hw_i (
    .clk_i(clk), .rst_ni(rst_n), .cal_pin_i(cal_pin), .cal_reg_i(cal_reg),
    .auto_mode_i(auto_mode), .auto_en_i(auto_en), .vref_ok_i(vref_ok),
    .gain_cfg_i(gain_cfg), .uni_cfg_i(uni_cfg), .short_o(sh[1]), .shunt_off_o(so[1]),
    .gain_o(gn[1]), .uni_o(un[1]), .busy_o(bz[1]), .trim_valid_o(tv[1]));

  // behavioural model: 0 idle, 1 manual settling, 2 manual hold, 3 auto
  int m_st [2][NCH];
  int m_cnt [2][NCH];
  bit m_trim [2][NCH];
  bit m_rq [2][NCH];
  bit m_pd [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_pd[i] = 1'b0;
        for (int c = 0; c < NCH; c++) begin
          m_st[i][c] = 0; m_cnt[i][c] = 0; m_trim[i][c] = 0; m_rq[i][c] = 0;
        end
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        bit hw, ea, pstart;
        hw = (i == 1);
        ea = auto_mode && !hw;
        pstart = vref_ok && !m_pd[i];
        for (int c = 0; c < NCH; c++) begin
          bit rq, rise;
          rq = cal_pin || (cal_reg[c] && !hw);
          rise = rq && !m_rq[i][c];
          if (pstart || (rise && ea && auto_en)) begin
            m_st[i][c] = 3; m_cnt[i][c] = N; m_trim[i][c] = 0;
          end else if (m_st[i][c] == 0) begin
            if (rq && !ea) begin m_st[i][c] = 1; m_cnt[i][c] = N; end
          end else if (m_st[i][c] == 1 || m_st[i][c] == 2) begin
            if (!rq) m_st[i][c] = 0;
            else if (m_st[i][c] == 1) begin
              m_cnt[i][c]--;
              if (m_cnt[i][c] == 0) m_st[i][c] = 2;
            end
          end else begin
            m_cnt[i][c]--;
            if (m_cnt[i][c] == 0) begin m_st[i][c] = 0; m_trim[i][c] = 1; end
          end
          m_rq[i][c] = rq;
        end
        if (vref_ok) m_pd[i] = 1'b1;
      end
    end
  end

  task automatic check(input string rq, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 2; i++) begin
        for (int c = 0; c < NCH; c++) begin
          bit au;
          au = (m_st[i][c] == 3);
          check("R1", "short", sh[i][c], m_st[i][c] != 0);
          check("R1", "shunt_off", so[i][c], m_st[i][c] != 0);
          check("R7", "gain", gn[i][c*GW +: GW], au ? 2'b11 : gain_cfg[c*GW +: GW]);
          check("R6", "uni", un[i][c], au ? 1'b0 : uni_cfg[c]);
          check("R8", "busy", bz[i][c], (m_st[i][c] == 1) || au);
          check("R5", "trim_valid", tv[i][c], m_trim[i][c]);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_begin();
    @(negedge clk); #1;
  endtask

  initial begin
    #(200_000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    check("R12", "reset short", sh[0], 3'b000);
    check("R12", "reset busy", bz[0], 3'b000);
    check("R12", "reset trim", tv[0], 3'b000);
    drive_begin(); rst_n = 1'b1;
    tick(2);

    // power-up auto
    drive_begin(); vref_ok = 1'b1;
    tick(3);
    check("R5", "pwrup busy", bz[0], 3'b111);
    check("R7", "pwrup gain", gn[0], 6'b111111);
    check("R6", "pwrup uni", un[0], 3'b000);
    tick(N);
    check("R5", "pwrup trim", tv[0], 3'b111);
    check("R7", "gain restored", gn[0], gain_cfg);
    check("R6", "uni restored", un[0], uni_cfg);
    drive_begin(); vref_ok = 1'b0;
    drive_begin(); vref_ok = 1'b1;
    tick(2);
    check("R5", "no second pwrup", bz[0], 3'b000);

    // manual via one register bit
    drive_begin(); cal_reg = 3'b010;
    tick(1);
    check("R2", "reg bit isolation", sh[0], 3'b010);
    check("R1", "shunt with short", so[0], 3'b010);
    check("R3", "manual busy", bz[0], 3'b010);
    tick(N);
    check("R8", "busy ends after window", bz[0], 3'b000);
    check("R8", "short held", sh[0], 3'b010);
    drive_begin(); cal_reg = 3'b000;
    tick(1);
    check("R11", "drop returns", sh[0], 3'b000);

    // manual via pin
    drive_begin(); cal_pin = 1'b1;
    tick(1);
    check("R2", "pin all channels", sh[0], 3'b111);
    drive_begin(); cal_pin = 1'b0;
    tick(1);

    // auto requested but disabled
    drive_begin(); auto_mode = 1'b1; auto_en = 1'b0; cal_pin = 1'b1;
    tick(3);
    check("R9", "disabled auto short", sh[0], 3'b000);
    check("R9", "disabled auto busy", bz[0], 3'b000);
    drive_begin(); cal_pin = 1'b0;
    tick(1);

    // run-time auto and retrigger
    drive_begin(); auto_en = 1'b1; cal_reg = 3'b001;
    tick(1);
    check("R3", "auto busy", bz[0], 3'b001);
    check("R3", "auto gain", gn[0][GW-1:0], 2'b11);
    tick(4);
    drive_begin(); cal_reg = 3'b000;
    drive_begin(); cal_reg = 3'b001;
    tick(9);
    check("R10", "window reloaded", bz[0][0], 1'b1);
    tick(2);
    check("R10", "reloaded window ends", bz[0][0], 1'b0);
    check("R5", "trim after run", tv[0][0], 1'b1);
    drive_begin(); cal_reg = 3'b000; auto_mode = 1'b0; auto_en = 1'b0;
    tick(2);

    // hardware-only variant
    drive_begin(); cal_reg = 3'b111;
    tick(2);
    check("R4", "hw reg ignored", sh[1], 3'b000);
    drive_begin(); cal_reg = 3'b000;
    tick(1);
    drive_begin(); auto_mode = 1'b1; auto_en = 1'b1; cal_pin = 1'b1;
    tick(1);
    check("R4", "hw pin manual", sh[1], 3'b111);
    check("R4", "hw no gain force", gn[1], gain_cfg);
    tick(N);
    check("R4", "hw manual hold", sh[1], 3'b111);
    check("R8", "hw busy over", bz[1], 3'b000);
    drive_begin(); cal_pin = 1'b0;
    tick(N + 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule